// File: doc/BRIEF.md
# Non-blocking multi-port translation buffer

This block translates virtual addresses to physical addresses for one shader core, with 4 KB pages. Each cycle it takes several lookups from the coalescing stage, one per lookup port. Each lookup carries a warp number. Translations are kept in a set-associative array of 32 sets by 4 ways, 128 entries in all. Every lookup port has its own copy of the read and compare logic, so ports that land in the same set are all served in the same cycle. One cycle after a lookup, each port reports exactly one outcome: hit (with the physical address), miss (queued) or retry.

A miss does not stall the other ports or later lookups. Pending pages are held in a small file of miss-status registers. Each register runs a three-state machine. FREE moves to SEND on *allocate*. SEND moves to WAIT on *issue*, when the walker accepts the request. WAIT moves back to FREE on *fill*. A register keeps the page number and a bit mask of the warps waiting on it. A new miss to a page that is already pending joins that register's mask, and no new walk request is made. When the walker answers with a fill, the translation is written into the array. Every warp in the matching register is reported in one wake-up mask a cycle later, and a lookup to the filled page in the fill cycle is answered from the fill itself.

Top module: `tlb_nb`

## Requirements
- R1: The physical address is the frame number followed by bits 11:0 of the virtual address, which pass through unchanged. The virtual page number is bits 31:12.
- R2: A lookup that finds its page reports `rsp_hit` with the physical address exactly one cycle after `lk_valid`. Every valid lookup reports exactly one of hit, miss or retry.
- R3: Lookups on all ports in one cycle that hit the same set are all answered as hits in the same cycle, each with its own address.
- R4: A lookup to a page with no entry and no pending register allocates a free register and reports `rsp_miss`. One cycle after that lookup, `walk_req_valid` is high with that page number. The request stays high until `walk_req_ready`.
- R5: A miss to a page that is already pending, in a later cycle or on another port in the same cycle, reports `rsp_miss` and adds its warp to that register. No second walk request is made for the page.
- R6: A fill for a pending page frees its register. One cycle later it raises `wake_valid`, with bit w of `wake_mask` set for exactly the warps that waited on that page. Later lookups to the page hit.
- R7: While walks are outstanding, lookups to present pages keep hitting in the same cycle as misses on other ports.
- R8: When no register is free, a new miss reports `rsp_retry`. It changes nothing: no walk request, and its warp never appears in a wake-up.
- R9: At most one register is allocated per cycle, by the lowest-numbered port with a new miss. A same-cycle new miss to a different page reports `rsp_retry`.
- R10: A lookup whose page equals `fill_vpn` while `fill_valid` is high reports a hit with the filled frame. It does not join the waiting warps.
- R11: A fill goes into the lowest-numbered invalid way of its set. If every way is valid, it goes into the way picked by a binary-tree pseudo-LRU. Each hit and each fill, applied in port order and fill last, sets the tree to point away from the way it used.
- R12: After reset no entry is valid, all registers are FREE, and no hit, miss, retry, walk request or wake-up is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | NPORT | Lookup valid, one bit per port |
| lk_va | input | NPORT x 32 | Virtual address per port |
| lk_warp | input | NPORT x 6 | Warp number per port |
| rsp_hit | output | NPORT | Hit, one cycle after the lookup |
| rsp_miss | output | NPORT | Miss queued in a pending register |
| rsp_retry | output | NPORT | Miss refused, lookup must be replayed |
| rsp_pa | output | NPORT x 32 | Physical address, valid with rsp_hit |
| walk_req_valid | output | 1 | Walk request to the page walker |
| walk_req_ready | input | 1 | Walker accepts the request |
| walk_req_vpn | output | 20 | Page number to walk |
| fill_valid | input | 1 | Walker returns a translation |
| fill_vpn | input | 20 | Page number of the returned translation |
| fill_pfn | input | 20 | Frame number of the returned translation |
| wake_valid | output | 1 | Wake-up report |
| wake_mask | output | 64 | Warps released by the fill |

## Verification
The bench builds the block with four lookup ports, 32 sets of 4 ways and the default widths, but with only two miss registers. With two registers, a single merged miss and one fresh allocation fill the whole file, so the refused-miss and one-allocation-per-cycle cases come up within a few lookups. Five pages mapped to one set fill all four ways, and then a single replacement shows whether the tree picks the less recently used way over the oldest fill.

// File: rtl/tlb_nb_pkg.sv
package tlb_nb_pkg;
    typedef enum logic [1:0] {
        MSHR_FREE = 2'd0,
        MSHR_SEND = 2'd1,
        MSHR_WAIT = 2'd2
    } mshr_state_e;
endpackage

// File: rtl/tlb_store.sv
module tlb_store #(
    parameter int NPORT = 4,
    parameter int VPN_W = 20,
    parameter int PFN_W = 20,
    parameter int SETS  = 32,
    parameter int WAYS  = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NPORT-1:0][VPN_W-1:0] rd_vpn,
    input  logic [NPORT-1:0]            touch,
    output logic [NPORT-1:0]            rd_hit,
    output logic [NPORT-1:0][PFN_W-1:0] rd_pfn,
    input  logic                        wr_en,
    input  logic [VPN_W-1:0]            wr_vpn,
    input  logic [PFN_W-1:0]            wr_pfn
);
    localparam int SET_W = $clog2(SETS);
    localparam int TAG_W = VPN_W - SET_W;
    localparam int WAY_W = $clog2(WAYS);

    logic [WAYS-1:0]  vld_q  [SETS];
    logic [TAG_W-1:0] tag_q  [SETS][WAYS];
    logic [PFN_W-1:0] pfn_q  [SETS][WAYS];
    logic [WAYS-1:1]  plru_q [SETS];
    logic [WAYS-1:1]  plru_d [SETS];

    logic [SET_W-1:0] rd_set  [NPORT];
    logic [WAY_W-1:0] hit_way [NPORT];

    function automatic logic [WAY_W-1:0] tree_victim(input logic [WAYS-1:1] b);
        int node;
        node = 1;
        for (int l = 0; l < WAY_W; l++) node = 2 * node + (b[node] ? 1 : 0);
        return WAY_W'(node - WAYS);
    endfunction

    function automatic logic [WAYS-1:1] tree_touch(input logic [WAYS-1:1] b,
                                                   input logic [WAY_W-1:0] w);
        logic [WAYS-1:1] r;
        r = b;
        for (int l = 0; l < WAY_W; l++) begin
            int node;
            node = (1 << l) + (int'(w) >> (WAY_W - l));
            r[node] = ~w[WAY_W-1-l];
        end
        return r;
    endfunction

    // one read/compare path per lookup port
    for (genvar p = 0; p < NPORT; p++) begin : g_rd
        logic             hit_l;
        logic [PFN_W-1:0] pfn_l;
        logic [WAY_W-1:0] way_l;
        logic [TAG_W-1:0] tag_l;
        assign rd_set[p] = rd_vpn[p][SET_W-1:0];
        assign tag_l     = rd_vpn[p][VPN_W-1:SET_W];
        always_comb begin
            hit_l = 1'b0;
            pfn_l = '0;
            way_l = '0;
            for (int w = 0; w < WAYS; w++) begin
                if (vld_q[rd_set[p]][w] && tag_q[rd_set[p]][w] == tag_l) begin
                    hit_l = 1'b1;
                    pfn_l = pfn_q[rd_set[p]][w];
                    way_l = WAY_W'(w);
                end
            end
        end
        assign rd_hit[p]  = hit_l;
        assign rd_pfn[p]  = pfn_l;
        assign hit_way[p] = way_l;
    end

    logic [SET_W-1:0] wr_set;
    logic [TAG_W-1:0] wr_tag;
    logic [WAY_W-1:0] wr_way;
    assign wr_set = wr_vpn[SET_W-1:0];
    assign wr_tag = wr_vpn[VPN_W-1:SET_W];

    always_comb begin
        wr_way = tree_victim(plru_q[wr_set]);
        for (int w = WAYS - 1; w >= 0; w--)
            if (!vld_q[wr_set][w]) wr_way = WAY_W'(w);
    end

    always_comb begin
        for (int s = 0; s < SETS; s++) plru_d[s] = plru_q[s];
        for (int p = 0; p < NPORT; p++)
            if (touch[p] && rd_hit[p])
                plru_d[rd_set[p]] = tree_touch(plru_d[rd_set[p]], hit_way[p]);
        if (wr_en) plru_d[wr_set] = tree_touch(plru_d[wr_set], wr_way);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                vld_q[s]  <= '0;
                plru_q[s] <= '0;
            end
        end else begin
            for (int s = 0; s < SETS; s++) plru_q[s] <= plru_d[s];
            if (wr_en) vld_q[wr_set][wr_way] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_set][wr_way] <= wr_tag;
            pfn_q[wr_set][wr_way] <= wr_pfn;
        end
    end

    // R11: a fill lands where a lookup of the same page then finds it
    p_fill_visible_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && touch[0] && rd_vpn[0] == wr_vpn) |=>
            (!touch[0] || rd_vpn[0] != $past(wr_vpn) || rd_hit[0]));
endmodule

// File: rtl/tlb_mshr_file.sv
module tlb_mshr_file
    import tlb_nb_pkg::*;
#(
    parameter int NMSHR = 4,
    parameter int VPN_W = 20,
    parameter int NWARP = 64
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        alloc_en,
    input  logic [VPN_W-1:0]            alloc_vpn,
    input  logic [NWARP-1:0]            alloc_mask,
    input  logic [NMSHR-1:0][NWARP-1:0] join_mask,
    output logic [NMSHR-1:0]            busy,
    output logic [NMSHR-1:0][VPN_W-1:0] busy_vpn,
    output logic                        free_any,
    output logic                        walk_req_valid,
    input  logic                        walk_req_ready,
    output logic [VPN_W-1:0]            walk_req_vpn,
    input  logic                        fill_valid,
    input  logic [VPN_W-1:0]            fill_vpn,
    output logic                        wake_valid,
    output logic [NWARP-1:0]            wake_mask
);
    localparam int IDX_W = (NMSHR > 1) ? $clog2(NMSHR) : 1;

    mshr_state_e      st_q [NMSHR];
    mshr_state_e      st_d [NMSHR];
    logic [VPN_W-1:0] vpn_q  [NMSHR];
    logic [NWARP-1:0] mask_q [NMSHR];

    logic [IDX_W-1:0] free_idx, issue_idx;
    logic             issue_any;
    logic [NMSHR-1:0] fill_hit;
    logic             wake_d;
    logic [NWARP-1:0] wake_mask_d;

    always_comb begin
        free_any  = 1'b0;
        free_idx  = '0;
        issue_any = 1'b0;
        issue_idx = '0;
        for (int m = NMSHR - 1; m >= 0; m--) begin
            if (st_q[m] == MSHR_FREE) begin
                free_any = 1'b1;
                free_idx = IDX_W'(m);
            end
            if (st_q[m] == MSHR_SEND) begin
                issue_any = 1'b1;
                issue_idx = IDX_W'(m);
            end
        end
    end

    for (genvar m = 0; m < NMSHR; m++) begin : g_view
        assign busy[m]     = (st_q[m] != MSHR_FREE);
        assign busy_vpn[m] = vpn_q[m];
        assign fill_hit[m] = fill_valid && st_q[m] == MSHR_WAIT && vpn_q[m] == fill_vpn;
    end

    // next-state: allocate, issue, fill
    always_comb begin
        for (int m = 0; m < NMSHR; m++) begin
            st_d[m] = st_q[m];
            unique case (st_q[m])
                MSHR_FREE: if (alloc_en && free_idx == IDX_W'(m)) st_d[m] = MSHR_SEND;
                MSHR_SEND: if (walk_req_ready && issue_idx == IDX_W'(m)) st_d[m] = MSHR_WAIT;
                MSHR_WAIT: if (fill_hit[m]) st_d[m] = MSHR_FREE;
                default:   st_d[m] = MSHR_FREE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int m = 0; m < NMSHR; m++) st_q[m] <= MSHR_FREE;
        end else begin
            for (int m = 0; m < NMSHR; m++) st_q[m] <= st_d[m];
        end
    end

    always_ff @(posedge clk) begin
        for (int m = 0; m < NMSHR; m++) begin
            if (st_q[m] == MSHR_FREE && alloc_en && free_idx == IDX_W'(m)) begin
                vpn_q[m]  <= alloc_vpn;
                mask_q[m] <= alloc_mask;
            end else begin
                mask_q[m] <= mask_q[m] | join_mask[m];
            end
        end
    end

    // outputs
    assign walk_req_valid = issue_any;
    assign walk_req_vpn   = vpn_q[issue_idx];

    always_comb begin
        wake_d      = |fill_hit;
        wake_mask_d = '0;
        for (int m = 0; m < NMSHR; m++)
            if (fill_hit[m]) wake_mask_d = wake_mask_d | mask_q[m];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wake_valid <= 1'b0;
            wake_mask  <= '0;
        end else begin
            wake_valid <= wake_d;
            wake_mask  <= wake_mask_d;
        end
    end

    p_no_alloc_when_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_en |-> free_any);
    p_wake_has_warps_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wake_valid |-> (wake_mask != '0));
    p_walk_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_req_valid && !walk_req_ready) |=> walk_req_valid);

    for (genvar i = 0; i < NMSHR; i++) begin : g_ui
        p_join_only_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (join_mask[i] != '0) |-> busy[i]);
        for (genvar j = i + 1; j < NMSHR; j++) begin : g_uj
            p_one_entry_per_page_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (busy[i] && busy[j]) |-> (busy_vpn[i] != busy_vpn[j]));
        end
    end
endmodule

// File: rtl/tlb_nb.sv
module tlb_nb #(
    parameter int NPORT     = 4,
    parameter int VA_W      = 32,
    parameter int PA_W      = 32,
    parameter int PAGE_BITS = 12,
    parameter int SETS      = 32,
    parameter int WAYS      = 4,
    parameter int NMSHR     = 4,
    parameter int WARP_W    = 6
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic [NPORT-1:0]                      lk_valid,
    input  logic [NPORT-1:0][VA_W-1:0]            lk_va,
    input  logic [NPORT-1:0][WARP_W-1:0]          lk_warp,
    output logic [NPORT-1:0]                      rsp_hit,
    output logic [NPORT-1:0]                      rsp_miss,
    output logic [NPORT-1:0]                      rsp_retry,
    output logic [NPORT-1:0][PA_W-1:0]            rsp_pa,
    output logic                                  walk_req_valid,
    input  logic                                  walk_req_ready,
    output logic [VA_W-PAGE_BITS-1:0]             walk_req_vpn,
    input  logic                                  fill_valid,
    input  logic [VA_W-PAGE_BITS-1:0]             fill_vpn,
    input  logic [PA_W-PAGE_BITS-1:0]             fill_pfn,
    output logic                                  wake_valid,
    output logic [(1<<WARP_W)-1:0]                wake_mask
);
    localparam int VPN_W = VA_W - PAGE_BITS;
    localparam int PFN_W = PA_W - PAGE_BITS;
    localparam int NWARP = 1 << WARP_W;

    logic [NPORT-1:0][VPN_W-1:0] vpn;
    logic [NPORT-1:0]            arr_hit;
    logic [NPORT-1:0][PFN_W-1:0] arr_pfn;
    logic [NMSHR-1:0]            busy;
    logic [NMSHR-1:0][VPN_W-1:0] busy_vpn;
    logic                        free_any;

    logic [NPORT-1:0]            hit_d, miss_d, retry_d;
    logic [NPORT-1:0][PFN_W-1:0] pfn_d;
    logic                        lead_found;
    logic [VPN_W-1:0]            lead_vpn;
    logic [NWARP-1:0]            alloc_mask;
    logic [NMSHR-1:0][NWARP-1:0] join_mask;

    for (genvar p = 0; p < NPORT; p++) begin : g_split
        assign vpn[p] = lk_va[p][VA_W-1:PAGE_BITS];
    end

    tlb_store #(
        .NPORT(NPORT), .VPN_W(VPN_W), .PFN_W(PFN_W), .SETS(SETS), .WAYS(WAYS)
    ) u_store (
        .clk(clk), .rst_n(rst_n),
        .rd_vpn(vpn), .touch(lk_valid), .rd_hit(arr_hit), .rd_pfn(arr_pfn),
        .wr_en(fill_valid), .wr_vpn(fill_vpn), .wr_pfn(fill_pfn)
    );

    tlb_mshr_file #(
        .NMSHR(NMSHR), .VPN_W(VPN_W), .NWARP(NWARP)
    ) u_mshr (
        .clk(clk), .rst_n(rst_n),
        .alloc_en(lead_found), .alloc_vpn(lead_vpn), .alloc_mask(alloc_mask),
        .join_mask(join_mask), .busy(busy), .busy_vpn(busy_vpn), .free_any(free_any),
        .walk_req_valid(walk_req_valid), .walk_req_ready(walk_req_ready),
        .walk_req_vpn(walk_req_vpn), .fill_valid(fill_valid), .fill_vpn(fill_vpn),
        .wake_valid(wake_valid), .wake_mask(wake_mask)
    );

    // per-port outcome: forward, hit, merge, allocate or refuse
    always_comb begin
        lead_found = 1'b0;
        lead_vpn   = '0;
        alloc_mask = '0;
        join_mask  = '0;
        for (int p = 0; p < NPORT; p++) begin
            logic fwd, merged, fresh;
            fwd      = fill_valid && vpn[p] == fill_vpn;
            hit_d[p] = lk_valid[p] && (arr_hit[p] || fwd);
            pfn_d[p] = fwd ? fill_pfn : arr_pfn[p];
            merged   = 1'b0;
            for (int m = 0; m < NMSHR; m++) begin
                if (lk_valid[p] && !hit_d[p] && busy[m] && busy_vpn[m] == vpn[p]) begin
                    join_mask[m][lk_warp[p]] = 1'b1;
                    merged = 1'b1;
                end
            end
            fresh = lk_valid[p] && !hit_d[p] && !merged;
            if (fresh && !lead_found && free_any) begin
                lead_found = 1'b1;
                lead_vpn   = vpn[p];
            end
            if (fresh && lead_found && vpn[p] == lead_vpn) alloc_mask[lk_warp[p]] = 1'b1;
            miss_d[p]  = merged || (fresh && lead_found && vpn[p] == lead_vpn);
            retry_d[p] = fresh && !(lead_found && vpn[p] == lead_vpn);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_hit   <= '0;
            rsp_miss  <= '0;
            rsp_retry <= '0;
            rsp_pa    <= '0;
        end else begin
            rsp_hit   <= hit_d;
            rsp_miss  <= miss_d;
            rsp_retry <= retry_d;
            for (int p = 0; p < NPORT; p++)
                rsp_pa[p] <= {pfn_d[p], lk_va[p][PAGE_BITS-1:0]};
        end
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_chk
        p_single_outcome_r2: assert property (@(posedge clk) disable iff (!rst_n)
            lk_valid[p] |=> ($countones({rsp_hit[p], rsp_miss[p], rsp_retry[p]}) == 1));
        p_quiet_when_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
            !lk_valid[p] |=> !(rsp_hit[p] || rsp_miss[p] || rsp_retry[p]));
        p_offset_kept_r1: assert property (@(posedge clk) disable iff (!rst_n)
            rsp_hit[p] |-> rsp_pa[p][PAGE_BITS-1:0] == $past(lk_va[p][PAGE_BITS-1:0]));
    end
endmodule

// File: tb/tlb_nb_test.sv
module tlb_nb_test;
    localparam int CLK_PERIOD = 10;
    localparam int NPORT = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NPORT-1:0]            lk_valid;
    logic [NPORT-1:0][31:0]      lk_va;
    logic [NPORT-1:0][5:0]       lk_warp;
    logic [NPORT-1:0]            rsp_hit, rsp_miss, rsp_retry;
    logic [NPORT-1:0][31:0]      rsp_pa;
    logic                        walk_req_valid;
    logic                        walk_req_ready;
    logic [19:0]                 walk_req_vpn;
    logic                        fill_valid;
    logic [19:0]                 fill_vpn, fill_pfn;
    logic                        wake_valid;
    logic [63:0]                 wake_mask;

    int checks = 0, errors = 0, walks = 0, cyc = 0;
    logic [19:0] last_walk = '0;
    bit done = 0;

    localparam logic [19:0] PA_ = 20'h00012, PB = 20'h00033, PC = 20'h00040,
                            PD = 20'h00051, PE = 20'h00062;

    tlb_nb #(.NPORT(NPORT), .NMSHR(2)) uut (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_va(lk_va), .lk_warp(lk_warp),
        .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_retry(rsp_retry), .rsp_pa(rsp_pa),
        .walk_req_valid(walk_req_valid), .walk_req_ready(walk_req_ready),
        .walk_req_vpn(walk_req_vpn), .fill_valid(fill_valid), .fill_vpn(fill_vpn),
        .fill_pfn(fill_pfn), .wake_valid(wake_valid), .wake_mask(wake_mask)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cyc++;
        if (rst_n && walk_req_valid && walk_req_ready) begin
            walks++;
            last_walk = walk_req_vpn;
        end
        if (cyc > 5000 && !done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog (all requirements) actual=%0d cycles expected<5000", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    function automatic logic [19:0] pfn_of(input logic [19:0] v);
        return v ^ 20'hA5C00;
    endfunction

    function automatic logic [19:0] set5(input int k);
        return 20'h00105 + 20'(32 * k);
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clear_lk();
        lk_valid = '0;
        lk_va    = '0;
        lk_warp  = '0;
    endtask

    task automatic put(input int p, input logic [19:0] v, input logic [11:0] off,
                       input logic [5:0] w);
        lk_valid[p] = 1'b1;
        lk_va[p]    = {v, off};
        lk_warp[p]  = w;
    endtask

    task automatic do_fill(input logic [19:0] v);
        fill_valid = 1'b1;
        fill_vpn   = v;
        fill_pfn   = pfn_of(v);
        step();
        fill_valid = 1'b0;
    endtask

    task automatic install(input logic [19:0] v, input logic [5:0] w);
        put(0, v, 12'h000, w);
        step();
        clear_lk();
        step();
        do_fill(v);
    endtask

    task automatic t_reset();
        chk("R12 hit", 64'(rsp_hit), 0);
        chk("R12 miss/retry", 64'({rsp_miss, rsp_retry}), 0);
        chk("R12 walk", 64'(walk_req_valid), 0);
        chk("R12 wake", 64'(wake_valid), 0);
    endtask

    task automatic t_miss_merge();
        put(0, PA_, 12'h100, 6'd3);
        step();
        clear_lk();
        chk("R4 miss reported", 64'(rsp_miss), 64'b0001);
        chk("R4 walk valid", 64'(walk_req_valid), 1);
        chk("R4 walk vpn", 64'(walk_req_vpn), 64'(PA_));
        put(1, PA_, 12'h200, 6'd5);
        put(2, PB, 12'h000, 6'd1);
        put(3, PB, 12'h000, 6'd2);
        step();
        clear_lk();
        chk("R5 merge and same-cycle join", 64'(rsp_miss), 64'b1110);
        step();
        chk("R5 one walk per page", 64'(walks), 2);
        chk("R5 second walk page", 64'(last_walk), 64'(PB));
    endtask

    task automatic t_full_retry();
        put(0, PC, 12'h000, 6'd9);
        step();
        clear_lk();
        chk("R8 retry when full", 64'(rsp_retry), 64'b0001);
        chk("R8 not queued", 64'(rsp_miss), 0);
        step();
        chk("R8 no walk", 64'(walks), 2);
    endtask

    task automatic t_fill_wake();
        do_fill(PA_);
        chk("R6 wake valid", 64'(wake_valid), 1);
        chk("R6/R8 wake warps", wake_mask, (64'd1 << 3) | (64'd1 << 5));
        put(0, PA_, 12'h345, 6'd0);
        step();
        clear_lk();
        chk("R2 hit after fill", 64'(rsp_hit), 64'b0001);
        chk("R1 address", 64'(rsp_pa[0]), 64'({pfn_of(PA_), 12'h345}));
        chk("R6 wake one cycle only", 64'(wake_valid), 0);
    endtask

    task automatic t_nonblocking();
        put(2, PA_, 12'hFFF, 6'd0);
        put(3, PB, 12'h010, 6'd7);
        step();
        clear_lk();
        chk("R7 hit beside miss", 64'(rsp_hit), 64'b0100);
        chk("R7 pending miss", 64'(rsp_miss), 64'b1000);
        chk("R7 address", 64'(rsp_pa[2]), 64'({pfn_of(PA_), 12'hFFF}));
    endtask

    task automatic t_one_alloc();
        put(0, PD, 12'h000, 6'd10);
        put(1, PE, 12'h000, 6'd11);
        step();
        clear_lk();
        chk("R9 lowest port allocates", 64'(rsp_miss), 64'b0001);
        chk("R9 other page retries", 64'(rsp_retry), 64'b0010);
        step();
        chk("R9 walks", 64'(walks), 3);
        chk("R9 walk page", 64'(last_walk), 64'(PD));
    endtask

    task automatic t_forward();
        put(1, PB, 12'hABC, 6'd4);
        do_fill(PB);
        clear_lk();
        chk("R10 forwarded hit", 64'(rsp_hit), 64'b0010);
        chk("R10 forwarded address", 64'(rsp_pa[1]), 64'({pfn_of(PB), 12'hABC}));
        chk("R10/R6 waiters woken", wake_mask, (64'd1 << 1) | (64'd1 << 2) | (64'd1 << 7));
        do_fill(PD);
        chk("R6 wake for second page", wake_mask, 64'd1 << 10);
    endtask

    task automatic t_same_set();
        for (int k = 0; k < 4; k++) install(set5(k), 6'(20 + k));
        for (int k = 0; k < 4; k++) put(k, set5(k), 12'(k * 12'h111), 6'd0);
        step();
        clear_lk();
        chk("R3 all ports hit", 64'(rsp_hit), 64'hF);
        for (int k = 0; k < 4; k++)
            chk("R3 per-port address", 64'(rsp_pa[k]), 64'({pfn_of(set5(k)), 12'(k * 12'h111)}));
    endtask

    task automatic t_replace();
        put(0, set5(0), 12'h000, 6'd0);
        step();
        clear_lk();
        chk("R11 refresh hit", 64'(rsp_hit), 64'b0001);
        install(set5(4), 6'd30);
        put(0, set5(0), 12'h000, 6'd0);
        put(1, set5(1), 12'h000, 6'd0);
        put(2, set5(3), 12'h000, 6'd0);
        put(3, set5(4), 12'h000, 6'd0);
        step();
        clear_lk();
        chk("R11 survivors hit", 64'(rsp_hit), 64'hF);
        put(0, set5(2), 12'h000, 6'd31);
        step();
        clear_lk();
        chk("R11 tree victim evicted", 64'(rsp_miss), 64'b0001);
    endtask

    initial begin
        clear_lk();
        walk_req_ready = 1'b1;
        fill_valid = 1'b0;
        fill_vpn = '0;
        fill_pfn = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_miss_merge();
        t_full_retry();
        t_fill_wake();
        t_nonblocking();
        t_one_alloc();
        t_forward();
        t_same_set();
        t_replace();
        step();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule